// File: doc/BRIEF.md
# Montgomery Ladder Point-Multiplication Sequencer

This block computes the projective ladder state for a scalar multiple of a point on a binary elliptic curve in López-Dahab coordinates. A single pulse on `start` captures the base-point x coordinate, the curve constant and the scalar. The block then runs a fixed program of single-cycle field instructions over an eight-word register file. The datapath has one field multiplier, which also serves for squaring, and one XOR adder. When the program ends, the block presents the two projective points (X1:Z1) and (X2:Z2) and holds `done` high. A later stage does the conversion back to affine form.

The scalar is supplied without its leading one. That bit is always treated as set, and the ladder walks the remaining bits from the most significant end down to bit 0. A run takes 4 setup cycles plus 14 cycles per walked bit. For each bit, seven instructions merge the two points and seven double one of them. A zero bit swaps which register pair each group acts on.

Top module: `ml_ladder_core`

## Requirements
- R1: While reset is held, and after its release until the first start, `busy` and `done` are 0 and all four coordinate outputs read 0.
- R2: A `start` seen while not busy captures `xp`, `b` and `key_lo`. `busy` is 1 from the next cycle for exactly 4 + 14·(M−1) cycles, and `done` rises in the cycle `busy` falls. `busy` and `done` are never 1 together.
- R3: Setup loads X1 = xp, Z1 = 1, Z2 = xp², X2 = xp⁴ + b before the first ladder step, including the case xp = 0.
- R4: For a scalar bit of 1, the step replaces (X1,Z1) with the differential sum of both points (Z = (X1·Z2 + X2·Z1)², X = xp·Z + X1·Z2·X2·Z1). It then replaces (X2,Z2) with its double (X = X2⁴ + b·Z2⁴, Z = X2²·Z2²).
- R5: For a scalar bit of 0, the same step runs with the pairs exchanged: the sum goes to (X2,Z2) and (X1,Z1) is doubled.
- R6: All field arithmetic is in GF(2^M) modulo x^M + POLY. The defaults are M = 13 and POLY = 13'h001B (x^13 + x^4 + x^3 + x + 1), and every result is fully reduced.
- R7: `start` asserted while busy has no effect: the result, the captured operands and the run length stay those of the run in progress.
- R8: While `done` is 1 and `start` is low, `done` and all four outputs stay unchanged. A `start` in this state begins a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch request, accepted when not busy |
| xp | input | M | Base-point x coordinate |
| b | input | M | Curve constant b |
| key_lo | input | M-1 | Scalar without its implied leading one |
| busy | output | 1 | Program running |
| done | output | 1 | Result valid, held until the next start |
| x1 | output | M | Projective X1 |
| z1 | output | M | Projective Z1 |
| x2 | output | M | Projective X2 |
| z2 | output | M | Projective Z2 |

## Verification
The bound checker watches the run timing on every cycle. It checks that each launch raises `busy`, that a run lasts exactly the programmed length and ends with `done`, that a mid-run start never stretches a run, and that the result is held steady while `done` is high. Only the bench scenarios can show that the arithmetic is right. The bench compares the outputs against a behavioural ladder computed from the ladder formulas. The scenarios cover all-one, all-zero and mixed scalars, operands that force reduction, a zero base coordinate, a start issued mid-run, and a restart from the finished state.

// File: rtl/ml_pkg.sv
// Shared types and the fixed instruction program of the ladder sequencer.
// Assumes the register file layout below; slots 0..3 form two pairs that a
// zero scalar bit exchanges by flipping address bit 1.
package ml_pkg;

    typedef enum logic [1:0] {
        OP_MUL = 2'd0,   // a * b
        OP_ADD = 2'd1,   // a ^ b
        OP_SQA = 2'd2,   // a * a ^ b
        OP_ONE = 2'd3    // constant 1
    } op_e;

    typedef logic [2:0] slot_t;

    localparam int NSLOT = 8;
    localparam slot_t SL_X1 = 3'd0;
    localparam slot_t SL_Z1 = 3'd1;
    localparam slot_t SL_X2 = 3'd2;
    localparam slot_t SL_Z2 = 3'd3;
    localparam slot_t SL_T  = 3'd4;
    localparam slot_t SL_XP = 3'd5;
    localparam slot_t SL_B  = 3'd6;
    localparam slot_t SL_SP = 3'd7;

    localparam int INIT_LEN = 4;
    localparam int STEP_LEN = 14;

    typedef struct packed {
        op_e   op;
        slot_t dst;
        slot_t sa;
        slot_t sb;
    } instr_t;

    // Setup program: projective P in pair 1, 2P in pair 2.
    function automatic instr_t init_instr(input logic [1:0] s);
        instr_t r;
        unique case (s)
            2'd0: r = '{OP_ONE, SL_Z1, SL_Z1, SL_Z1};
            2'd1: r = '{OP_MUL, SL_X1, SL_XP, SL_Z1};
            2'd2: r = '{OP_MUL, SL_Z2, SL_XP, SL_XP};
            2'd3: r = '{OP_SQA, SL_X2, SL_Z2, SL_B};
        endcase
        return r;
    endfunction

    // Per-bit program written for a one bit: merge into pair 1, double pair 2.
    function automatic instr_t step_instr(input logic [3:0] s);
        instr_t r;
        case (s)
            4'd0:    r = '{OP_MUL, SL_Z1, SL_X2, SL_Z1};
            4'd1:    r = '{OP_MUL, SL_X1, SL_X1, SL_Z2};
            4'd2:    r = '{OP_ADD, SL_T,  SL_X1, SL_Z1};
            4'd3:    r = '{OP_MUL, SL_X1, SL_X1, SL_Z1};
            4'd4:    r = '{OP_MUL, SL_Z1, SL_T,  SL_T};
            4'd5:    r = '{OP_MUL, SL_T,  SL_XP, SL_Z1};
            4'd6:    r = '{OP_ADD, SL_X1, SL_X1, SL_T};
            4'd7:    r = '{OP_MUL, SL_Z2, SL_Z2, SL_Z2};
            4'd8:    r = '{OP_MUL, SL_T,  SL_Z2, SL_Z2};
            4'd9:    r = '{OP_MUL, SL_T,  SL_B,  SL_T};
            4'd10:   r = '{OP_MUL, SL_X2, SL_X2, SL_X2};
            4'd11:   r = '{OP_MUL, SL_Z2, SL_X2, SL_Z2};
            4'd12:   r = '{OP_MUL, SL_X2, SL_X2, SL_X2};
            4'd13:   r = '{OP_ADD, SL_X2, SL_X2, SL_T};
            default: r = '{OP_ADD, SL_SP, SL_SP, SL_SP};
        endcase
        return r;
    endfunction

    // Exchange the two coordinate pairs when swap is set.
    function automatic slot_t remap(input slot_t s, input logic swap);
        return (swap && !s[2]) ? {s[2], ~s[1], s[0]} : s;
    endfunction

endpackage

// File: rtl/ml_gf_mul.sv
// Combinational GF(2^M) multiplier, most significant multiplier bit first,
// reducing after every shift. Assumes POLY holds x^M + POLY's low terms.
module ml_gf_mul #(
    parameter int          M    = 13,
    parameter logic [M-1:0] POLY = 13'h001B
) (
    input  logic [M-1:0] a,
    input  logic [M-1:0] b,
    output logic [M-1:0] p
);
    logic [M-1:0] acc;

    // Horner evaluation of a*b with interleaved reduction.
    always_comb begin
        acc = '0;
        for (int i = M - 1; i >= 0; i--) begin
            acc = {acc[M-2:0], 1'b0} ^ (acc[M-1] ? POLY : '0);
            if (b[i]) acc = acc ^ a;
        end
        p = acc;
    end
endmodule

// File: rtl/ml_field_alu.sv
// Single-cycle field unit: product, sum, square-plus-addend or constant one.
// Assumes operands are already reduced.
module ml_field_alu
    import ml_pkg::*;
#(
    parameter int          M    = 13,
    parameter logic [M-1:0] POLY = 13'h001B
) (
    input  op_e          op,
    input  logic [M-1:0] a,
    input  logic [M-1:0] b,
    output logic [M-1:0] y
);
    logic [M-1:0] mul_b;
    logic [M-1:0] prod;

    // Squaring feeds the same operand to both multiplier inputs.
    assign mul_b = (op == OP_SQA) ? a : b;

    ml_gf_mul #(.M(M), .POLY(POLY)) u_mul (.a(a), .b(mul_b), .p(prod));

    // Select the instruction's result.
    always_comb begin
        unique case (op)
            OP_MUL: y = prod;
            OP_ADD: y = a ^ b;
            OP_SQA: y = prod ^ b;
            OP_ONE: y = M'(1);
        endcase
    end
endmodule

// File: rtl/ml_regfile.sv
// Eight-word register file: two combinational read ports, one write port,
// plus a load path that fills the base-coordinate and constant slots.
// Assumes load and write are never requested in the same cycle.
module ml_regfile
    import ml_pkg::*;
#(
    parameter int M = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [M-1:0] ld_xp,
    input  logic [M-1:0] ld_b,
    input  logic         we,
    input  slot_t        wa,
    input  logic [M-1:0] wd,
    input  slot_t        ra,
    input  slot_t        rb,
    output logic [M-1:0] qa,
    output logic [M-1:0] qb,
    output logic [M-1:0] q_x1,
    output logic [M-1:0] q_z1,
    output logic [M-1:0] q_x2,
    output logic [M-1:0] q_z2
);
    logic [M-1:0] mem [NSLOT];

    // Storage update: clear on reset, load inputs, or write a result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSLOT; i++) mem[i] <= '0;
        end else if (ld) begin
            mem[SL_XP] <= ld_xp;
            mem[SL_B]  <= ld_b;
        end else if (we) begin
            mem[wa] <= wd;
        end
    end

    assign qa   = mem[ra];
    assign qb   = mem[rb];
    assign q_x1 = mem[SL_X1];
    assign q_z1 = mem[SL_Z1];
    assign q_x2 = mem[SL_X2];
    assign q_z2 = mem[SL_Z2];
endmodule

// File: rtl/ml_ladder_core.sv
// Ladder sequencer top: captures operands on start, runs 4 setup
// instructions then 14 per scalar bit from M-2 down to 0, one per cycle,
// and holds the projective result with done. Assumes M >= 3.
module ml_ladder_core
    import ml_pkg::*;
#(
    parameter int          M    = 13,
    parameter logic [M-1:0] POLY = 13'h001B
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [M-1:0] xp,
    input  logic [M-1:0] b,
    input  logic [M-2:0] key_lo,
    output logic         busy,
    output logic         done,
    output logic [M-1:0] x1,
    output logic [M-1:0] z1,
    output logic [M-1:0] x2,
    output logic [M-1:0] z2
);
    localparam int IW = (M - 1 > 1) ? $clog2(M - 1) : 1;
    localparam logic [IW-1:0] TOP_IDX = IW'(M - 2);
    localparam logic [3:0] LAST_INIT = 4'(INIT_LEN - 1);
    localparam logic [3:0] LAST_STEP = 4'(STEP_LEN - 1);

    typedef enum logic [1:0] {ST_IDLE, ST_INIT, ST_LOOP, ST_DONE} state_e;

    state_e        state_q;
    logic [3:0]    step_q;
    logic [IW-1:0] idx_q;
    logic [M-2:0]  key_q;

    logic          accept;
    logic          swap;
    instr_t        cur;
    slot_t         wa, ra, rb;
    logic [M-1:0]  qa, qb, res;

    assign accept = start && (state_q == ST_IDLE || state_q == ST_DONE);
    assign busy   = (state_q == ST_INIT) || (state_q == ST_LOOP);
    assign done   = (state_q == ST_DONE);

    // Decode the current instruction and steer it to the active pair roles.
    always_comb begin
        cur  = (state_q == ST_INIT) ? init_instr(step_q[1:0]) : step_instr(step_q);
        swap = (state_q == ST_LOOP) && !key_q[idx_q];
        wa   = remap(cur.dst, swap);
        ra   = remap(cur.sa, swap);
        rb   = remap(cur.sb, swap);
    end

    // Sequencer: phase, instruction counter and scalar bit index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
            idx_q   <= '0;
            key_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_DONE: begin
                    if (accept) begin
                        state_q <= ST_INIT;
                        step_q  <= '0;
                        key_q   <= key_lo;
                    end
                end
                ST_INIT: begin
                    if (step_q == LAST_INIT) begin
                        state_q <= ST_LOOP;
                        step_q  <= '0;
                        idx_q   <= TOP_IDX;
                    end else begin
                        step_q <= step_q + 4'd1;
                    end
                end
                ST_LOOP: begin
                    if (step_q == LAST_STEP) begin
                        step_q <= '0;
                        if (idx_q == '0) state_q <= ST_DONE;
                        else             idx_q   <= idx_q - 1'b1;
                    end else begin
                        step_q <= step_q + 4'd1;
                    end
                end
            endcase
        end
    end

    ml_regfile #(.M(M)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (accept),
        .ld_xp (xp),
        .ld_b  (b),
        .we    (busy),
        .wa    (wa),
        .wd    (res),
        .ra    (ra),
        .rb    (rb),
        .qa    (qa),
        .qb    (qb),
        .q_x1  (x1),
        .q_z1  (z1),
        .q_x2  (x2),
        .q_z2  (z2)
    );

    ml_field_alu #(.M(M), .POLY(POLY)) u_alu (
        .op (cur.op),
        .a  (qa),
        .b  (qb),
        .y  (res)
    );
endmodule

// File: rtl/ml_ladder_chk.sv
// Timing checker for the ladder sequencer: launch, run length, completion
// and result hold. Counts busy cycles itself so no deep $past is needed.
module ml_ladder_chk #(
    parameter int M = 13
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [M-1:0] x1,
    input logic [M-1:0] z1,
    input logic [M-1:0] x2,
    input logic [M-1:0] z2
);
    localparam int RUN_LEN = 4 + 14 * (M - 1);
    localparam int CW = $clog2(RUN_LEN + 1) + 1;

    logic [CW-1:0] run_cnt;

    // Count consecutive busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)    run_cnt <= '0;
        else if (busy) run_cnt <= run_cnt + 1'b1;
        else           run_cnt <= '0;
    end

    // R2
    launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && !done));

    // R2
    run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_cnt == CW'(RUN_LEN)));

    // R2
    finish_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R2
    excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R7
    no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_cnt < CW'(RUN_LEN)));

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(x1) && $stable(z1)
                              && $stable(x2) && $stable(z2)));
endmodule

bind ml_ladder_core ml_ladder_chk #(.M(M)) u_ml_ladder_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done),
    .x1    (x1),
    .z1    (z1),
    .x2    (x2),
    .z2    (z2)
);

// File: tb/test_ml_ladder_core.sv
// Bench: behavioural ladder and run-timing model, compared every cycle.
module test_ml_ladder_core;
    localparam int M = 13;
    localparam logic [M-1:0] POLY = 13'h001B;
    localparam int RUN = 4 + 14 * (M - 1);
    localparam logic [2*M-2:0] PFULL = {{(M-2){1'b0}}, 1'b1, POLY};

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [M-1:0] xp = '0, b = '0;
    logic [M-2:0] key_lo = '0;
    logic         busy, done;
    logic [M-1:0] x1, z1, x2, z2;

    ml_ladder_core #(.M(M), .POLY(POLY)) i_ml_ladder_core (
        .clk(clk), .rst_n(rst_n), .start(start), .xp(xp), .b(b),
        .key_lo(key_lo), .busy(busy), .done(done),
        .x1(x1), .z1(z1), .x2(x2), .z2(z2)
    );

    int    total = 0;
    int    bad = 0;
    string tag = "R1";

    task automatic chk(input string t, input string what,
                       input logic [M-1:0] act, input logic [M-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", t, what, act, exp);
        end
    endtask

    // Full product then reduction from the top (R6).
    function automatic logic [M-1:0] fmul(input logic [M-1:0] a, input logic [M-1:0] c);
        logic [2*M-2:0] p = '0;
        for (int i = 0; i < M; i++)
            if (c[i]) p = p ^ ((2*M-1)'(a) << i);
        for (int i = 2*M-2; i >= M; i--)
            if (p[i]) p = p ^ (PFULL << (i - M));
        return p[M-1:0];
    endfunction

    // Ladder from its formulas (R3, R4, R5).
    task automatic ladder(input logic [M-1:0] x, input logic [M-1:0] c,
                          input logic [M-2:0] k,
                          output logic [M-1:0] ox1, output logic [M-1:0] oz1,
                          output logic [M-1:0] ox2, output logic [M-1:0] oz2);
        logic [M-1:0] pa, pb, sx, sz, dx, dz, ax, az, bx, bz, x2s, z2s;
        ax = x; az = M'(1);
        bz = fmul(x, x);
        bx = fmul(bz, bz) ^ c;
        for (int i = M - 2; i >= 0; i--) begin
            pa = fmul(ax, bz); pb = fmul(bx, az);
            sz = fmul(pa ^ pb, pa ^ pb);
            sx = fmul(x, sz) ^ fmul(pa, pb);
            if (k[i]) begin x2s = bx; z2s = bz; end
            else      begin x2s = ax; z2s = az; end
            dx = fmul(fmul(x2s, x2s), fmul(x2s, x2s))
                 ^ fmul(c, fmul(fmul(z2s, z2s), fmul(z2s, z2s)));
            dz = fmul(fmul(x2s, x2s), fmul(z2s, z2s));
            if (k[i]) begin ax = sx; az = sz; bx = dx; bz = dz; end
            else      begin bx = sx; bz = sz; ax = dx; az = dz; end
        end
        ox1 = ax; oz1 = az; ox2 = bx; oz2 = bz;
    endtask

    // Reference model state, advanced on every rising edge.
    logic         e_busy = 1'b0, e_done = 1'b0;
    int           left = 0;
    logic [M-1:0] e_x1 = '0, e_z1 = '0, e_x2 = '0, e_z2 = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            e_busy = 1'b0; e_done = 1'b0; left = 0;
            e_x1 = '0; e_z1 = '0; e_x2 = '0; e_z2 = '0;
        end else if (e_busy) begin
            left = left - 1;
            if (left == 0) begin e_busy = 1'b0; e_done = 1'b1; end
        end else if (start) begin
            e_busy = 1'b1; e_done = 1'b0; left = RUN;
            ladder(xp, b, key_lo, e_x1, e_z1, e_x2, e_z2);
        end
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2", "busy", M'(busy), M'(e_busy));
            chk("R2", "done", M'(done), M'(e_done));
            if (!e_busy) begin
                chk(tag, "x1", x1, e_x1);
                chk(tag, "z1", z1, e_z1);
                chk(tag, "x2", x2, e_x2);
                chk(tag, "z2", z2, e_z2);
            end
        end
    end

    task automatic go(input string t, input logic [M-1:0] gx, input logic [M-1:0] gb,
                      input logic [M-2:0] gk);
        @(negedge clk);
        tag = t; xp = gx; b = gb; key_lo = gk; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int n = 0; n < RUN + 20 && !done; n++) @(negedge clk);
        chk(t, "done reached", M'(done), M'(1));
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [M-1:0] r_x1, r_z1, r_x2, r_z2;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "busy in reset", M'(busy), '0);
        chk("R1", "done in reset", M'(done), '0);
        chk("R1", "x1 in reset", x1, '0);
        chk("R1", "z2 in reset", z2, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "idle after reset", M'(busy | done), '0);

        go("R4", 13'h0ABC, 13'h1357, 12'hFFF);
        go("R5", 13'h1D2E, 13'h0421, 12'h000);
        go("R4", 13'h0F0F, 13'h1111, 12'hA5C);
        go("R6", 13'h1FFF, 13'h1FFF, 12'h3C3);
        go("R3", 13'h0000, 13'h0777, 12'h555);

        // R7: start pulse in the middle of a run, with other operands
        ladder(13'h1234, 13'h0BEE, 12'h9A6, r_x1, r_z1, r_x2, r_z2);
        @(negedge clk);
        tag = "R7"; xp = 13'h1234; b = 13'h0BEE; key_lo = 12'h9A6; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (50) @(negedge clk);
        xp = 13'h0001; b = 13'h0002; key_lo = 12'h001; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int n = 0; n < RUN + 20 && !done; n++) @(negedge clk);
        chk("R7", "x1 after ignored start", x1, r_x1);
        chk("R7", "z1 after ignored start", z1, r_z1);
        chk("R7", "x2 after ignored start", x2, r_x2);
        chk("R7", "z2 after ignored start", z2, r_z2);

        // R8: result held while idle in done, inputs changing
        tag = "R8";
        for (int n = 0; n < 10; n++) begin
            xp = xp + 13'h0101; key_lo = key_lo ^ 12'h0F0;
            @(negedge clk);
            chk("R8", "done held", M'(done), M'(1));
            chk("R8", "x1 held", x1, r_x1);
            chk("R8", "z1 held", z1, r_z1);
        end
        go("R8", 13'h0765, 13'h1ABC, 12'h7E1);

        for (int n = 0; n < 4; n++)
            go("R4", M'($urandom), M'($urandom), (M-1)'($urandom));

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule